// File: doc/BRIEF.md
# Banked UART Host Register Decoder

This block is the host-facing register file of a 16550-class UART with extended features. A host reaches it through a 3-bit address, a chip select, separate read and write strobes and an 8-bit data bus. The block holds the configuration registers: line control, interrupt enable, modem control, the divisor bytes, the fractional divisor, the enhanced function and feature control registers, the enhanced mode register, the scratch byte and four flow-control characters. Status values that the UART core produces (receive data, interrupt status, line status, modem status and FIFO fill level) come in as ports and are only multiplexed onto the read bus.

The same eight addresses reach different registers depending on stored state. If the line control byte holds the key value 0xBF, an extended bank opens. If line control bit 7 is set and the key is not present, the divisor bank is open. Otherwise the working bank is open. Bit 4 of the enhanced function register unlocks the fractional divisor and modem status writes. Bit 6 of feature control reassigns address 7. When both divisor bytes are zero, reads in the divisor bank return constant revision and identity bytes. Accesses with side effects in the core are passed on as single-cycle strobes, and the core takes the data from the write bus.

Top module: `uart_regbank`

## Requirements
- R1: After the active-low reset every held register reads 0x00, no strobe is raised, and rdata is 0x00.
- R2: With line control equal to 0xBF, addresses map as follows: 0 reads the FIFO level input and ignores writes; 1 is feature control; 2 is enhanced function; 4, 5, 6 and 7 are the first on-character, second on-character, first off-character and second off-character. All of these except address 0 are read/write.
- R3: With line control bit 7 set and line control not 0xBF, address 0 is the divisor low byte and address 1 is the divisor high byte, both read/write.
- R4: In the divisor bank, while both divisor bytes are 0x00, a read of address 0 returns parameter REV_BYTE (default 0x01) and a read of address 1 returns parameter ID_BYTE (default 0x0A). Writes still reach the divisor bytes.
- R5: Address 2 is the fractional divisor (read/write) only in the divisor bank while enhanced function bit 4 is 1.
- R6: In the working bank, and in the divisor bank while enhanced function bit 4 is 0, a read of address 2 returns interrupt status and pulses isr_rd_o, and a write pulses fcr_wr_o.
- R7: In the working bank, a read of address 0 returns rhr_data and pulses rhr_rd_o, a write pulses thr_wr_o, and address 1 is interrupt enable (read/write).
- R8: Outside the extended bank, address 4 is modem control (read/write), address 5 reads line status, and address 6 reads modem status. A write to address 6 pulses msr_wr_o only while enhanced function bit 4 is 1.
- R9: Outside the extended bank with feature control bit 6 equal to 0, address 7 is the scratch byte. With that bit equal to 1, writes go to the enhanced mode register and reads return the FIFO level input.
- R10: Address 3 reads and writes line control in every bank.
- R11: Writes to read-only locations change no register and raise no strobe. A read of a location with no readable register returns 0x00, and rdata is 0x00 whenever no read is active.
- R12: Each strobe is high only in a cycle where cs and the matching read or write strobe are high, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data; also the data for thr, fcr and msr strobes |
| rdata | output | 8 | Read data, combinational, 0 when no read |
| rhr_data | input | 8 | Receive holding byte from core |
| isr_stat | input | 8 | Interrupt status from core |
| lsr_stat | input | 8 | Line status from core |
| msr_stat | input | 8 | Modem status from core |
| fifo_lvl | input | 8 | FIFO level count from core |
| lcr_o | output | 8 | Line control |
| ier_o | output | 8 | Interrupt enable |
| mcr_o | output | 8 | Modem control |
| dll_o | output | 8 | Divisor low byte |
| dlm_o | output | 8 | Divisor high byte |
| dld_o | output | 8 | Fractional divisor |
| efr_o | output | 8 | Enhanced function |
| fctr_o | output | 8 | Feature control |
| emsr_o | output | 8 | Enhanced mode |
| spr_o | output | 8 | Scratch byte |
| xon1_o | output | 8 | First on-character |
| xon2_o | output | 8 | Second on-character |
| xoff1_o | output | 8 | First off-character |
| xoff2_o | output | 8 | Second off-character |
| thr_wr_o | output | 1 | Transmit byte write strobe |
| fcr_wr_o | output | 1 | FIFO control write strobe |
| msr_wr_o | output | 1 | Modem status write strobe |
| isr_rd_o | output | 1 | Interrupt status read strobe |
| rhr_rd_o | output | 1 | Receive byte read strobe |

## Verification
A wrong bank choice or a stale gating bit shows in the same cycle as the access. The read bus carries a value from the wrong source, or the wrong strobe fires. A write that lands in the wrong register shows one cycle later on that register's output port. It also shows as a missing change on the register that should have taken it. Because every register output, rdata and every strobe are compared each cycle, a corrupted decode shows up within one cycle of the first access it touches.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    typedef enum logic [4:0] {
        T_NONE, T_RHR, T_THR, T_IER, T_ISR, T_FCR, T_LCR, T_MCR,
        T_LSR, T_MSR, T_SPR, T_EMSR, T_FC, T_DLL, T_DLM, T_DLD,
        T_DREV, T_DVID, T_FCTR, T_EFR, T_XON1, T_XON2, T_XOFF1, T_XOFF2
    } tgt_e;

    typedef struct packed {
        logic [7:0] lcr;
        logic [7:0] ier;
        logic [7:0] mcr;
        logic [7:0] dll;
        logic [7:0] dlm;
        logic [7:0] dld;
        logic [7:0] efr;
        logic [7:0] fctr;
        logic [7:0] emsr;
        logic [7:0] spr;
        logic [7:0] xon1;
        logic [7:0] xon2;
        logic [7:0] xoff1;
        logic [7:0] xoff2;
    } regs_t;

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
    import uart_regbank_pkg::*;
#(
    parameter int         AW      = 3,
    parameter logic [7:0] ENH_KEY = 8'hBF
) (
    input  logic [AW-1:0] addr,
    input  logic [7:0]    lcr,
    input  logic          efr_unlock,
    input  logic          fctr_a7sel,
    input  logic          div_zero,
    output tgt_e          rd_tgt,
    output tgt_e          wr_tgt
);
    logic enh_bank;
    logic div_bank;

    assign enh_bank = (lcr == ENH_KEY);
    assign div_bank = lcr[7] && !enh_bank;

    always_comb begin
        rd_tgt = T_NONE;
        wr_tgt = T_NONE;
        case (addr)
            3'd0: begin
                if (enh_bank) begin
                    rd_tgt = T_FC;
                end else if (div_bank) begin
                    rd_tgt = div_zero ? T_DREV : T_DLL;
                    wr_tgt = T_DLL;
                end else begin
                    rd_tgt = T_RHR;
                    wr_tgt = T_THR;
                end
            end
            3'd1: begin
                if (enh_bank) begin
                    rd_tgt = T_FCTR;
                    wr_tgt = T_FCTR;
                end else if (div_bank) begin
                    rd_tgt = div_zero ? T_DVID : T_DLM;
                    wr_tgt = T_DLM;
                end else begin
                    rd_tgt = T_IER;
                    wr_tgt = T_IER;
                end
            end
            3'd2: begin
                if (enh_bank) begin
                    rd_tgt = T_EFR;
                    wr_tgt = T_EFR;
                end else if (div_bank && efr_unlock) begin
                    rd_tgt = T_DLD;
                    wr_tgt = T_DLD;
                end else begin
                    rd_tgt = T_ISR;
                    wr_tgt = T_FCR;
                end
            end
            3'd3: begin
                rd_tgt = T_LCR;
                wr_tgt = T_LCR;
            end
            3'd4: begin
                rd_tgt = enh_bank ? T_XON1 : T_MCR;
                wr_tgt = enh_bank ? T_XON1 : T_MCR;
            end
            3'd5: begin
                rd_tgt = enh_bank ? T_XON2 : T_LSR;
                wr_tgt = enh_bank ? T_XON2 : T_NONE;
            end
            3'd6: begin
                if (enh_bank) begin
                    rd_tgt = T_XOFF1;
                    wr_tgt = T_XOFF1;
                end else begin
                    rd_tgt = T_MSR;
                    wr_tgt = efr_unlock ? T_MSR : T_NONE;
                end
            end
            default: begin
                if (enh_bank) begin
                    rd_tgt = T_XOFF2;
                    wr_tgt = T_XOFF2;
                end else if (fctr_a7sel) begin
                    rd_tgt = T_FC;
                    wr_tgt = T_EMSR;
                end else begin
                    rd_tgt = T_SPR;
                    wr_tgt = T_SPR;
                end
            end
        endcase
    end
endmodule

// File: rtl/uart_reg_store.sv
module uart_reg_store
    import uart_regbank_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  tgt_e          wr_tgt,
    input  logic [DW-1:0] wdata,
    output regs_t         regs_q,
    output logic          thr_wr,
    output logic          fcr_wr,
    output logic          msr_wr
);
    regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_tgt)
                T_LCR:   regs_d.lcr   = wdata;
                T_IER:   regs_d.ier   = wdata;
                T_MCR:   regs_d.mcr   = wdata;
                T_DLL:   regs_d.dll   = wdata;
                T_DLM:   regs_d.dlm   = wdata;
                T_DLD:   regs_d.dld   = wdata;
                T_EFR:   regs_d.efr   = wdata;
                T_FCTR:  regs_d.fctr  = wdata;
                T_EMSR:  regs_d.emsr  = wdata;
                T_SPR:   regs_d.spr   = wdata;
                T_XON1:  regs_d.xon1  = wdata;
                T_XON2:  regs_d.xon2  = wdata;
                T_XOFF1: regs_d.xoff1 = wdata;
                T_XOFF2: regs_d.xoff2 = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign thr_wr = wr_en && (wr_tgt == T_THR);
    assign fcr_wr = wr_en && (wr_tgt == T_FCR);
    assign msr_wr = wr_en && (wr_tgt == T_MSR);

    assert_lcr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == T_LCR) |=> (regs_q.lcr == $past(wdata)));

    assert_dll_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_q.dll) |-> ($past(wr_en) && $past(regs_q.lcr[7])
                                  && $past(regs_q.lcr) != 8'hBF));

    assert_efr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_q.efr) |-> ($past(regs_q.lcr) == 8'hBF));

    assert_dld_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_q.dld) |-> $past(regs_q.efr[4]));

    assert_msr_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msr_wr |-> regs_q.efr[4]);
endmodule

// File: rtl/uart_rd_mux.sv
module uart_rd_mux
    import uart_regbank_pkg::*;
#(
    parameter int         DW       = 8,
    parameter logic [7:0] REV_BYTE = 8'h01,
    parameter logic [7:0] ID_BYTE  = 8'h0A
) (
    input  logic          rd_en,
    input  tgt_e          rd_tgt,
    input  regs_t         regs_q,
    input  logic [DW-1:0] rhr_data,
    input  logic [DW-1:0] isr_stat,
    input  logic [DW-1:0] lsr_stat,
    input  logic [DW-1:0] msr_stat,
    input  logic [DW-1:0] fifo_lvl,
    output logic [DW-1:0] rdata,
    output logic          isr_rd,
    output logic          rhr_rd
);
    logic [DW-1:0] sel;

    always_comb begin
        case (rd_tgt)
            T_RHR:   sel = rhr_data;
            T_ISR:   sel = isr_stat;
            T_LSR:   sel = lsr_stat;
            T_MSR:   sel = msr_stat;
            T_FC:    sel = fifo_lvl;
            T_DREV:  sel = REV_BYTE;
            T_DVID:  sel = ID_BYTE;
            T_LCR:   sel = regs_q.lcr;
            T_IER:   sel = regs_q.ier;
            T_MCR:   sel = regs_q.mcr;
            T_DLL:   sel = regs_q.dll;
            T_DLM:   sel = regs_q.dlm;
            T_DLD:   sel = regs_q.dld;
            T_EFR:   sel = regs_q.efr;
            T_FCTR:  sel = regs_q.fctr;
            T_SPR:   sel = regs_q.spr;
            T_XON1:  sel = regs_q.xon1;
            T_XON2:  sel = regs_q.xon2;
            T_XOFF1: sel = regs_q.xoff1;
            T_XOFF2: sel = regs_q.xoff2;
            default: sel = '0;
        endcase
    end

    assign rdata  = rd_en ? sel : '0;
    assign isr_rd = rd_en && (rd_tgt == T_ISR);
    assign rhr_rd = rd_en && (rd_tgt == T_RHR);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int         AW       = 3,
    parameter int         DW       = 8,
    parameter logic [7:0] ENH_KEY  = 8'hBF,
    parameter logic [7:0] REV_BYTE = 8'h01,
    parameter logic [7:0] ID_BYTE  = 8'h0A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] rhr_data,
    input  logic [DW-1:0] isr_stat,
    input  logic [DW-1:0] lsr_stat,
    input  logic [DW-1:0] msr_stat,
    input  logic [DW-1:0] fifo_lvl,
    output logic [DW-1:0] lcr_o,
    output logic [DW-1:0] ier_o,
    output logic [DW-1:0] mcr_o,
    output logic [DW-1:0] dll_o,
    output logic [DW-1:0] dlm_o,
    output logic [DW-1:0] dld_o,
    output logic [DW-1:0] efr_o,
    output logic [DW-1:0] fctr_o,
    output logic [DW-1:0] emsr_o,
    output logic [DW-1:0] spr_o,
    output logic [DW-1:0] xon1_o,
    output logic [DW-1:0] xon2_o,
    output logic [DW-1:0] xoff1_o,
    output logic [DW-1:0] xoff2_o,
    output logic          thr_wr_o,
    output logic          fcr_wr_o,
    output logic          msr_wr_o,
    output logic          isr_rd_o,
    output logic          rhr_rd_o
);
    localparam int UNLOCK_BIT = 4;
    localparam int A7SEL_BIT  = 6;

    regs_t regs_q;
    tgt_e  rd_tgt;
    tgt_e  wr_tgt;
    logic  rd_en;
    logic  wr_en;
    logic  div_zero;

    assign rd_en    = cs && rd;
    assign wr_en    = cs && wr;
    assign div_zero = (regs_q.dll == '0) && (regs_q.dlm == '0);

    uart_bank_decode #(.AW(AW), .ENH_KEY(ENH_KEY)) u_dec (
        .addr       (addr),
        .lcr        (regs_q.lcr),
        .efr_unlock (regs_q.efr[UNLOCK_BIT]),
        .fctr_a7sel (regs_q.fctr[A7SEL_BIT]),
        .div_zero   (div_zero),
        .rd_tgt     (rd_tgt),
        .wr_tgt     (wr_tgt)
    );

    uart_reg_store #(.DW(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_tgt (wr_tgt),
        .wdata  (wdata),
        .regs_q (regs_q),
        .thr_wr (thr_wr_o),
        .fcr_wr (fcr_wr_o),
        .msr_wr (msr_wr_o)
    );

    uart_rd_mux #(.DW(DW), .REV_BYTE(REV_BYTE), .ID_BYTE(ID_BYTE)) u_rmux (
        .rd_en    (rd_en),
        .rd_tgt   (rd_tgt),
        .regs_q   (regs_q),
        .rhr_data (rhr_data),
        .isr_stat (isr_stat),
        .lsr_stat (lsr_stat),
        .msr_stat (msr_stat),
        .fifo_lvl (fifo_lvl),
        .rdata    (rdata),
        .isr_rd   (isr_rd_o),
        .rhr_rd   (rhr_rd_o)
    );

    assign lcr_o   = regs_q.lcr;
    assign ier_o   = regs_q.ier;
    assign mcr_o   = regs_q.mcr;
    assign dll_o   = regs_q.dll;
    assign dlm_o   = regs_q.dlm;
    assign dld_o   = regs_q.dld;
    assign efr_o   = regs_q.efr;
    assign fctr_o  = regs_q.fctr;
    assign emsr_o  = regs_q.emsr;
    assign spr_o   = regs_q.spr;
    assign xon1_o  = regs_q.xon1;
    assign xon2_o  = regs_q.xon2;
    assign xoff1_o = regs_q.xoff1;
    assign xoff2_o = regs_q.xoff2;

    assert_strobe_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({thr_wr_o, fcr_wr_o, msr_wr_o, isr_rd_o, rhr_rd_o}));

    assert_strobe_needs_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_o || fcr_wr_o || msr_wr_o) |-> (cs && wr));

    assert_idle_rdata_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> (rdata == '0));

    assert_enh_no_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_o == ENH_KEY) |-> !(thr_wr_o || fcr_wr_o || msr_wr_o || isr_rd_o || rhr_rd_o));
endmodule

// File: tb/uart_regbank_tb.sv
`timescale 1ns/1ps
module uart_regbank_tb;
    localparam time CLK_P = 20ns;
    localparam logic [7:0] REV = 8'h01;
    localparam logic [7:0] DID = 8'h0A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 0, rd = 0, wr = 0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rhr_data = 8'h5A, isr_stat = 8'hC1, lsr_stat = 8'h60;
    logic [7:0] msr_stat = 8'hB0, fifo_lvl = 8'h07;
    logic [7:0] rdata, lcr_o, ier_o, mcr_o, dll_o, dlm_o, dld_o, efr_o, fctr_o;
    logic [7:0] emsr_o, spr_o, xon1_o, xon2_o, xoff1_o, xoff2_o;
    logic thr_wr_o, fcr_wr_o, msr_wr_o, isr_rd_o, rhr_rd_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] m_reg [string];
    logic [7:0] e_rd;
    logic [4:0] e_stb;

    always #(CLK_P/2) clk = ~clk;

    uart_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rhr_data(rhr_data), .isr_stat(isr_stat),
        .lsr_stat(lsr_stat), .msr_stat(msr_stat), .fifo_lvl(fifo_lvl),
        .lcr_o(lcr_o), .ier_o(ier_o), .mcr_o(mcr_o), .dll_o(dll_o), .dlm_o(dlm_o),
        .dld_o(dld_o), .efr_o(efr_o), .fctr_o(fctr_o), .emsr_o(emsr_o),
        .spr_o(spr_o), .xon1_o(xon1_o), .xon2_o(xon2_o), .xoff1_o(xoff1_o),
        .xoff2_o(xoff2_o), .thr_wr_o(thr_wr_o), .fcr_wr_o(fcr_wr_o),
        .msr_wr_o(msr_wr_o), .isr_rd_o(isr_rd_o), .rhr_rd_o(rhr_rd_o)
    );

    task automatic model_reset();
        string names[14] = '{"lcr","ier","mcr","dll","dlm","dld","efr","fctr",
                             "emsr","spr","xon1","xon2","xoff1","xoff2"};
        foreach (names[i]) m_reg[names[i]] = 8'h00;
    endtask

    // Behavioural map: returns expected read byte / strobes, and the name of
    // the register a write would land in ("" when none).
    task automatic model_eval(output logic [7:0] rv, output logic [4:0] stb,
                              output string dest);
        bit ext, dv, unl, a7, zero;
        ext  = (m_reg["lcr"] == 8'hBF);
        dv   = m_reg["lcr"][7] && !ext;
        unl  = m_reg["efr"][4];
        a7   = m_reg["fctr"][6];
        zero = (m_reg["dll"] == 0) && (m_reg["dlm"] == 0);
        rv = 8'h00; stb = 5'b0; dest = "";
        // stb bits: 4 thr, 3 fcr, 2 msr, 1 isr, 0 rhr
        if (ext) begin
            case (addr)
                0: rv = fifo_lvl;
                1: begin rv = m_reg["fctr"];  dest = "fctr";  end
                2: begin rv = m_reg["efr"];   dest = "efr";   end
                3: begin rv = m_reg["lcr"];   dest = "lcr";   end
                4: begin rv = m_reg["xon1"];  dest = "xon1";  end
                5: begin rv = m_reg["xon2"];  dest = "xon2";  end
                6: begin rv = m_reg["xoff1"]; dest = "xoff1"; end
                default: begin rv = m_reg["xoff2"]; dest = "xoff2"; end
            endcase
        end else begin
            case (addr)
                0: if (dv) begin rv = zero ? REV : m_reg["dll"]; dest = "dll"; end
                   else begin rv = rhr_data; stb[0] = rd; stb[4] = wr; end
                1: if (dv) begin rv = zero ? DID : m_reg["dlm"]; dest = "dlm"; end
                   else begin rv = m_reg["ier"]; dest = "ier"; end
                2: if (dv && unl) begin rv = m_reg["dld"]; dest = "dld"; end
                   else begin rv = isr_stat; stb[1] = rd; stb[3] = wr; end
                3: begin rv = m_reg["lcr"]; dest = "lcr"; end
                4: begin rv = m_reg["mcr"]; dest = "mcr"; end
                5: rv = lsr_stat;
                6: begin rv = msr_stat; stb[2] = wr && unl; end
                default: if (a7) begin rv = fifo_lvl; dest = "emsr"; end
                         else begin rv = m_reg["spr"]; dest = "spr"; end
            endcase
        end
        if (!(cs && rd)) begin rv = 8'h00; stb[1:0] = 2'b00; end
        if (!(cs && wr)) begin stb[4:2] = 3'b000; end
    endtask

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        string d;
        model_eval(e_rd, e_stb, d);
        chk(tag, "rdata", rdata, e_rd);
        chk(tag, "strobes", {3'b0, thr_wr_o, fcr_wr_o, msr_wr_o, isr_rd_o, rhr_rd_o},
            {3'b0, e_stb});
        chk(tag, "lcr", lcr_o, m_reg["lcr"]);     chk(tag, "ier", ier_o, m_reg["ier"]);
        chk(tag, "mcr", mcr_o, m_reg["mcr"]);     chk(tag, "dll", dll_o, m_reg["dll"]);
        chk(tag, "dlm", dlm_o, m_reg["dlm"]);     chk(tag, "dld", dld_o, m_reg["dld"]);
        chk(tag, "efr", efr_o, m_reg["efr"]);     chk(tag, "fctr", fctr_o, m_reg["fctr"]);
        chk(tag, "emsr", emsr_o, m_reg["emsr"]);  chk(tag, "spr", spr_o, m_reg["spr"]);
        chk(tag, "xon1", xon1_o, m_reg["xon1"]);  chk(tag, "xon2", xon2_o, m_reg["xon2"]);
        chk(tag, "xoff1", xoff1_o, m_reg["xoff1"]);
        chk(tag, "xoff2", xoff2_o, m_reg["xoff2"]);
    endtask

    // One bus cycle: drive after a rising edge, compare at the falling edge,
    // then let the model take the write at the next rising edge.
    task automatic cyc(string tag, logic c, logic r, logic w, logic [2:0] a, logic [7:0] d);
        string dest;
        logic [7:0] rv;
        logic [4:0] sb;
        cs = c; rd = r; wr = w; addr = a; wdata = d;
        @(negedge clk);
        compare_all(tag);
        @(posedge clk);
        model_eval(rv, sb, dest);
        if (c && w && dest != "") m_reg[dest] = d;
        #1;
    endtask

    task automatic wr_(string tag, logic [2:0] a, logic [7:0] d); cyc(tag, 1, 0, 1, a, d); endtask
    task automatic rd_(string tag, logic [2:0] a); cyc(tag, 1, 1, 0, a, 8'h00); endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(posedge clk); #1;
        rd_("R1", 3'd1);
        cyc("R11", 0, 0, 0, 3'd3, 8'h00);

        // working bank
        wr_("R7", 3'd1, 8'h0F);  rd_("R7", 3'd1);
        rd_("R7", 3'd0);         wr_("R7", 3'd0, 8'h41);
        rd_("R6", 3'd2);         wr_("R6", 3'd2, 8'hC7);
        wr_("R8", 3'd4, 8'h0B);  rd_("R8", 3'd4);
        rd_("R8", 3'd5);         wr_("R11", 3'd5, 8'hFF); rd_("R11", 3'd5);
        rd_("R8", 3'd6);         wr_("R8", 3'd6, 8'h33);
        wr_("R9", 3'd7, 8'hA5);  rd_("R9", 3'd7);
        cyc("R12", 0, 1, 1, 3'd0, 8'h99);

        // divisor bank, divisor zero
        wr_("R10", 3'd3, 8'h83);
        rd_("R4", 3'd0);         rd_("R4", 3'd1);
        wr_("R6", 3'd2, 8'h01);  rd_("R6", 3'd2);
        wr_("R3", 3'd0, 8'h12);  rd_("R3", 3'd0);  rd_("R3", 3'd1);
        wr_("R3", 3'd1, 8'h34);  rd_("R3", 3'd1);
        rd_("R10", 3'd3);

        // extended bank
        wr_("R10", 3'd3, 8'hBF);
        rd_("R2", 3'd0);         wr_("R2", 3'd0, 8'h77); rd_("R2", 3'd0);
        wr_("R2", 3'd1, 8'h40);  wr_("R2", 3'd2, 8'h10);
        wr_("R2", 3'd4, 8'h11);  wr_("R2", 3'd5, 8'h13);
        wr_("R2", 3'd6, 8'h91);  wr_("R2", 3'd7, 8'h93);
        rd_("R2", 3'd1); rd_("R2", 3'd2); rd_("R2", 3'd4);
        rd_("R2", 3'd5); rd_("R2", 3'd6); rd_("R2", 3'd7);
        rd_("R10", 3'd3);

        // divisor bank with unlock
        wr_("R10", 3'd3, 8'h80);
        wr_("R5", 3'd2, 8'h0C);  rd_("R5", 3'd2);
        wr_("R8", 3'd6, 8'h5C);
        wr_("R3", 3'd0, 8'h00);  wr_("R3", 3'd1, 8'h00);
        rd_("R4", 3'd0);         rd_("R4", 3'd1);

        // working bank with unlock and address-7 swap
        wr_("R10", 3'd3, 8'h03);
        rd_("R6", 3'd2);         wr_("R6", 3'd2, 8'h06);
        wr_("R9", 3'd7, 8'h2D);  rd_("R9", 3'd7);
        rd_("R12", 3'd0);

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] a;
            logic [7:0] d;
            int k;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom);
            k = $urandom_range(0, 9);
            rhr_data = 8'($urandom); isr_stat = 8'($urandom);
            lsr_stat = 8'($urandom); msr_stat = 8'($urandom);
            fifo_lvl = 8'($urandom);
            if (a == 3'd3 && k < 6) d = (k < 2) ? 8'hBF : (k < 4) ? 8'h80 : 8'h00;
            if (k < 4)      cyc("R12", 1, 0, 1, a, d);
            else if (k < 8) cyc("R11", 1, 1, 0, a, d);
            else            cyc("R11", k[0], 1'b0, 1'b0, a, d);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule